// File: doc/BRIEF.md
# Dual-Channel Output-Compare Reference Generator

This block holds two output-compare channels that sit beside an up/down timer counter. On every clock edge each channel reads the counter value, the count direction, its own compare value and a 4-bit mode code. From these it produces a registered reference level. Depending on the mode, that level latches or toggles on an equality match, is forced to a fixed level, follows a pulse-width comparison, or runs a one-pulse cycle that is started by an external trigger pulse and ended by the counter's update-event pulse.

Channel A also drives a combined reference. In the pairing modes this output merges the references of both channels: by OR, by AND, or by choosing one of them according to the count direction. This gives centre-aligned and phase-shifted waveforms. In every other mode the combined reference simply repeats channel A's reference.

The counter itself lives outside the block. All outputs are registered. A change on any input, including the mode code, shows at the outputs one clock edge later.

Top module: `ocref_pair`

## Requirements
- R1: Reset (synchronous, active high) drives both references and the combined output low. It also clears both channels' one-pulse armed state.
- R2: Mode 0 and the reserved codes 10 and 11 keep the reference at its previous value, whatever the counter does.
- R3: Mode 1 sets the reference high when counter equals compare. Mode 2 clears it low on that match. Without a match, either mode holds the reference.
- R4: Mode 3 inverts the reference on each clock edge where counter equals compare, and holds it otherwise.
- R5: Mode 4 drives the reference low and mode 5 drives it high, whatever the counter and compare values.
- R6: Mode 6 (first PWM form) gives high while counter < compare when counting up (direction input 0). When counting down (direction input 1) it gives high while counter <= compare.
- R7: Mode 7 gives the exact inverse of mode 6 for the same inputs.
- R8: In mode 8, a channel that is not armed shows an idle level: high when counting up, low when counting down. A trigger pulse arms the channel in the same edge, and an armed channel follows the first PWM form. An update pulse without a trigger disarms it.
- R9: In mode 9, the idle level is low when counting up and high when counting down. An armed channel follows the second PWM form (mode 7). Arming and disarming work as in R8.
- R10: With channel A in mode 12, channel A follows the first PWM form and the combined output is the OR of both channels' references. In mode 13, channel A follows the second PWM form and the combined output is their AND.
- R11: With channel A in mode 14 (first PWM form) or 15 (second PWM form), the combined output equals channel A's reference when counting up and channel B's reference when counting down.
- R12: In any mode of channel A other than 12 to 15, the combined output equals channel A's reference.
- R13: A trigger that arrives while a channel is already armed keeps it armed, even if an update pulse arrives on the same edge. The trigger takes priority over the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CNT_W | Current counter value |
| cnt_down | input | 1 | Count direction, 1 = counting down |
| upd_evt | input | 1 | Counter update-event pulse |
| trig_evt | input | 1 | External trigger pulse |
| cmp_val | input | 2 x CNT_W | Compare value per channel (index 0 = A, 1 = B) |
| mode_sel | input | 2 x 4 | Mode code per channel |
| ref_out | output | 2 | Registered reference per channel |
| comb_out | output | 1 | Registered combined reference of channel A |

## Verification
The one-pulse armed state is the hardest condition to reach, because no port shows it. The stimulus infers it from the reference level. It parks the counter on a value where the idle level and the PWM comparison disagree, so the output reveals whether the channel is armed. It then drives a trigger and an update on the same edge and moves the counter to a value where only an armed channel would change its output. The same method checks that reset clears the armed state: a channel is armed, reset is applied, and the first post-reset cycle must show the idle level.

// File: rtl/ocref_pkg.sv
package ocref_pkg;
  typedef enum logic [3:0] {
    OC_FROZEN  = 4'd0,
    OC_SET     = 4'd1,
    OC_CLR     = 4'd2,
    OC_TOG     = 4'd3,
    OC_LOW     = 4'd4,
    OC_HIGH    = 4'd5,
    OC_PWM_A   = 4'd6,
    OC_PWM_B   = 4'd7,
    OC_OPM_A   = 4'd8,
    OC_OPM_B   = 4'd9,
    OC_RSV_A   = 4'd10,
    OC_RSV_B   = 4'd11,
    OC_CMB_OR  = 4'd12,
    OC_CMB_AND = 4'd13,
    OC_ASYM_A  = 4'd14,
    OC_ASYM_B  = 4'd15
  } oc_mode_e;
endpackage

// File: rtl/ocref_chan.sv
module ocref_chan
  import ocref_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic             upd_evt,
  input  logic             trig_evt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [3:0]       mode,
  output logic             ref_nxt,
  output logic             ref_q
);
  logic     armed_q, armed_nxt;
  logic     hit, pwm_a;
  oc_mode_e m;

  // trigger wins over update so a retrigger keeps the cycle running
  always_comb begin
    if (trig_evt)     armed_nxt = 1'b1;
    else if (upd_evt) armed_nxt = 1'b0;
    else              armed_nxt = armed_q;
  end

  always_comb begin
    m     = oc_mode_e'(mode);
    hit   = (cnt == cmp);
    pwm_a = cnt_down ? (cnt <= cmp) : (cnt < cmp);
    case (m)
      OC_SET:                ref_nxt = hit ? 1'b1 : ref_q;
      OC_CLR:                ref_nxt = hit ? 1'b0 : ref_q;
      OC_TOG:                ref_nxt = hit ? ~ref_q : ref_q;
      OC_LOW:                ref_nxt = 1'b0;
      OC_HIGH:               ref_nxt = 1'b1;
      OC_PWM_A, OC_CMB_OR,
      OC_ASYM_A:             ref_nxt = pwm_a;
      OC_PWM_B, OC_CMB_AND,
      OC_ASYM_B:             ref_nxt = ~pwm_a;
      OC_OPM_A:              ref_nxt = armed_nxt ? pwm_a : ~cnt_down;
      OC_OPM_B:              ref_nxt = armed_nxt ? ~pwm_a : cnt_down;
      default:               ref_nxt = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ref_q   <= ref_nxt;
      armed_q <= armed_nxt;
    end
  end

  // R5
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd4) |=> !ref_q);
  // R5
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd5) |=> ref_q);
  // R2
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd0 || mode == 4'd10 || mode == 4'd11) |=> $stable(ref_q));
  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd3 && cnt == cmp) |=> (ref_q != $past(ref_q)));
  // R8
  opm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd8 && upd_evt && !trig_evt) |=> (ref_q == !$past(cnt_down)));
endmodule

// File: rtl/ocref_comb.sv
module ocref_comb (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode,
  input  logic       cnt_down,
  input  logic       nxt_a,
  input  logic       nxt_b,
  output logic       comb_q
);
  logic comb_nxt;

  always_comb begin
    case (mode)
      4'd12:        comb_nxt = nxt_a | nxt_b;
      4'd13:        comb_nxt = nxt_a & nxt_b;
      4'd14, 4'd15: comb_nxt = cnt_down ? nxt_b : nxt_a;
      default:      comb_nxt = nxt_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) comb_q <= 1'b0;
    else     comb_q <= comb_nxt;
  end
endmodule

// File: rtl/ocref_pair.sv
module ocref_pair #(
  parameter int CNT_W = 16,
  localparam int NCH  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CNT_W-1:0]          cnt,
  input  logic                      cnt_down,
  input  logic                      upd_evt,
  input  logic                      trig_evt,
  input  logic [NCH-1:0][CNT_W-1:0] cmp_val,
  input  logic [NCH-1:0][3:0]       mode_sel,
  output logic [NCH-1:0]            ref_out,
  output logic                      comb_out
);
  logic [NCH-1:0] ref_nxt;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ocref_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .cnt      (cnt),
      .cnt_down (cnt_down),
      .upd_evt  (upd_evt),
      .trig_evt (trig_evt),
      .cmp      (cmp_val[i]),
      .mode     (mode_sel[i]),
      .ref_nxt  (ref_nxt[i]),
      .ref_q    (ref_out[i])
    );
  end

  ocref_comb u_comb (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_sel[0]),
    .cnt_down (cnt_down),
    .nxt_a    (ref_nxt[0]),
    .nxt_b    (ref_nxt[1]),
    .comb_q   (comb_out)
  );

  // R10
  cmb_or_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[0] == 4'd12) |=> (comb_out == (ref_out[0] | ref_out[1])));
  // R10
  cmb_and_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[0] == 4'd13) |=> (comb_out == (ref_out[0] & ref_out[1])));
  // R11
  asym_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[0][3:1] == 3'b111) |=>
      (comb_out == ($past(cnt_down) ? ref_out[1] : ref_out[0])));
  // R12
  plain_comb_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[0][3:2] != 2'b11) |=> (comb_out == ref_out[0]));
endmodule

// File: tb/sim_ocref_pair.sv
`timescale 1ns/1ps
module sim_ocref_pair;
  localparam int CW = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [CW-1:0]      cnt = '0;
  logic               cnt_down = 1'b0;
  logic               upd_evt = 1'b0;
  logic               trig_evt = 1'b0;
  logic [1:0][CW-1:0] cmp_val = '0;
  logic [1:0][3:0]    mode_sel = '0;
  logic [1:0]         ref_out;
  logic               comb_out;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic  ea, eb, ec;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  ocref_pair #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .cnt(cnt), .cnt_down(cnt_down),
    .upd_evt(upd_evt), .trig_evt(trig_evt), .cmp_val(cmp_val),
    .mode_sel(mode_sel), .ref_out(ref_out), .comb_out(comb_out)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic step(input int c, input bit dn, input bit up, input bit tg,
                      input logic [3:0] ma, input logic [3:0] mb,
                      input int ca, input int cb,
                      input bit ea, input bit eb, input bit ec, input string tag);
    exp_t e;
    @(negedge clk);
    cnt = CW'(c); cnt_down = dn; upd_evt = up; trig_evt = tg;
    mode_sel[0] = ma; mode_sel[1] = mb;
    cmp_val[0] = CW'(ca); cmp_val[1] = CW'(cb);
    e.ea = ea; e.eb = eb; e.ec = ec; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare just after the edge that registered the stimulus
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "ref_a", ref_out[0], e.ea);
      chk(e.tag, "ref_b", ref_out[1], e.eb);
      chk(e.tag, "comb",  comb_out,   e.ec);
    end
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ref_a reset", ref_out[0], 1'b0);
    chk("R1", "ref_b reset", ref_out[1], 1'b0);
    chk("R1", "comb reset", comb_out, 1'b0);
    rst = 1'b0;
    // R5 / R12 forced levels
    step(0, 0, 0, 0, 4'd5, 4'd4, 0, 0, 1, 0, 1, "R5");
    step(0, 0, 0, 0, 4'd4, 4'd4, 0, 0, 0, 0, 0, "R5");
    // R3 set on match
    step(5, 0, 0, 0, 4'd1, 4'd4, 9, 0, 0, 0, 0, "R3");
    step(9, 0, 0, 0, 4'd1, 4'd4, 9, 0, 1, 0, 1, "R3");
    // R2 frozen and reserved hold
    step(9, 0, 0, 0, 4'd0, 4'd4, 9, 0, 1, 0, 1, "R2");
    step(3, 0, 0, 0, 4'd10, 4'd4, 9, 0, 1, 0, 1, "R2");
    step(3, 0, 0, 0, 4'd11, 4'd4, 3, 0, 1, 0, 1, "R2");
    // R3 clear on match
    step(3, 0, 0, 0, 4'd2, 4'd4, 9, 0, 1, 0, 1, "R3");
    step(9, 0, 0, 0, 4'd2, 4'd4, 9, 0, 0, 0, 0, "R3");
    step(9, 0, 0, 0, 4'd0, 4'd5, 9, 0, 0, 1, 0, "R2");
    // R4 toggle
    step(9, 0, 0, 0, 4'd3, 4'd4, 9, 0, 1, 0, 1, "R4");
    step(9, 0, 0, 0, 4'd3, 4'd4, 9, 0, 0, 0, 0, "R4");
    step(8, 0, 0, 0, 4'd3, 4'd4, 9, 0, 0, 0, 0, "R4");
    step(9, 0, 0, 0, 4'd3, 4'd4, 9, 0, 1, 0, 1, "R4");
    // R6 first PWM form
    step(9, 0, 0, 0, 4'd6, 4'd4, 10, 0, 1, 0, 1, "R6");
    step(10, 0, 0, 0, 4'd6, 4'd4, 10, 0, 0, 0, 0, "R6");
    step(11, 0, 0, 0, 4'd6, 4'd4, 10, 0, 0, 0, 0, "R6");
    step(11, 1, 0, 0, 4'd6, 4'd4, 10, 0, 0, 0, 0, "R6");
    step(10, 1, 0, 0, 4'd6, 4'd4, 10, 0, 1, 0, 1, "R6");
    step(0, 1, 0, 0, 4'd6, 4'd4, 10, 0, 1, 0, 1, "R6");
    step(0, 0, 0, 0, 4'd6, 4'd4, 0, 0, 0, 0, 0, "R6");
    // R7 second PWM form
    step(9, 0, 0, 0, 4'd7, 4'd4, 10, 0, 0, 0, 0, "R7");
    step(10, 0, 0, 0, 4'd7, 4'd4, 10, 0, 1, 0, 1, "R7");
    step(10, 1, 0, 0, 4'd7, 4'd4, 10, 0, 0, 0, 0, "R7");
    step(11, 1, 0, 0, 4'd7, 4'd4, 10, 0, 1, 0, 1, "R7");
    // R8 one-pulse, first form
    step(12, 0, 0, 0, 4'd8, 4'd4, 10, 0, 1, 0, 1, "R8");
    step(12, 0, 0, 1, 4'd8, 4'd4, 10, 0, 0, 0, 0, "R8");
    step(5, 0, 0, 0, 4'd8, 4'd4, 10, 0, 1, 0, 1, "R8");
    step(12, 0, 0, 0, 4'd8, 4'd4, 10, 0, 0, 0, 0, "R8");
    step(12, 0, 1, 0, 4'd8, 4'd4, 10, 0, 1, 0, 1, "R8");
    step(5, 1, 0, 0, 4'd8, 4'd4, 10, 0, 0, 0, 0, "R8");
    step(5, 1, 0, 1, 4'd8, 4'd4, 10, 0, 1, 0, 1, "R8");
    step(12, 1, 0, 0, 4'd8, 4'd4, 10, 0, 0, 0, 0, "R8");
    // R13 retrigger beats simultaneous update
    step(5, 1, 1, 1, 4'd8, 4'd4, 10, 0, 1, 0, 1, "R13");
    step(12, 1, 0, 0, 4'd8, 4'd4, 10, 0, 0, 0, 0, "R13");
    step(5, 1, 1, 0, 4'd8, 4'd4, 10, 0, 0, 0, 0, "R8");
    // R9 one-pulse, second form
    step(12, 0, 0, 0, 4'd9, 4'd4, 10, 0, 0, 0, 0, "R9");
    step(12, 0, 0, 1, 4'd9, 4'd4, 10, 0, 1, 0, 1, "R9");
    step(5, 0, 0, 0, 4'd9, 4'd4, 10, 0, 0, 0, 0, "R9");
    step(12, 0, 1, 0, 4'd9, 4'd4, 10, 0, 0, 0, 0, "R9");
    step(5, 1, 0, 0, 4'd9, 4'd4, 10, 0, 1, 0, 1, "R9");
    step(5, 1, 0, 1, 4'd9, 4'd4, 10, 0, 0, 0, 0, "R9");
    step(5, 1, 1, 0, 4'd9, 4'd4, 10, 0, 1, 0, 1, "R9");
    // R10 combined OR / AND
    step(2, 0, 0, 0, 4'd12, 4'd6, 10, 4, 1, 1, 1, "R10");
    step(6, 0, 0, 0, 4'd12, 4'd6, 10, 4, 1, 0, 1, "R10");
    step(12, 0, 0, 0, 4'd12, 4'd6, 10, 4, 0, 0, 0, "R10");
    step(12, 0, 0, 0, 4'd12, 4'd7, 10, 4, 0, 1, 1, "R10");
    step(12, 0, 0, 0, 4'd13, 4'd6, 10, 4, 1, 0, 0, "R10");
    step(2, 0, 0, 0, 4'd13, 4'd6, 10, 4, 0, 1, 0, "R10");
    step(12, 0, 0, 0, 4'd13, 4'd7, 10, 4, 1, 1, 1, "R10");
    // R11 asymmetric
    step(2, 0, 0, 0, 4'd14, 4'd7, 10, 4, 1, 0, 1, "R11");
    step(2, 1, 0, 0, 4'd14, 4'd7, 10, 4, 1, 0, 0, "R11");
    step(12, 1, 0, 0, 4'd14, 4'd7, 10, 4, 0, 1, 1, "R11");
    step(6, 0, 0, 0, 4'd15, 4'd7, 10, 4, 0, 1, 0, "R11");
    step(6, 1, 0, 0, 4'd15, 4'd7, 10, 4, 0, 1, 1, "R11");
    // R12 plain mode, channels differ
    step(2, 0, 0, 0, 4'd6, 4'd7, 10, 4, 1, 0, 1, "R12");
    // R1 reset clears armed state
    step(12, 0, 0, 1, 4'd8, 4'd4, 10, 0, 0, 0, 0, "R1");
    @(negedge clk);
    trig_evt = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "ref_a reset", ref_out[0], 1'b0);
    chk("R1", "comb reset", comb_out, 1'b0);
    rst = 1'b0;
    step(12, 0, 0, 0, 4'd8, 4'd4, 10, 0, 1, 0, 1, "R1");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule